// File: doc/BRIEF.md
# Three-Phase Triangle Pulse-Density Synthesizer

This block turns a stream of filtered phase-error steps into three triangle waveforms spaced a third of a period apart. Each waveform leaves the block as a one-bit pulse-density stream. A step strobe and a direction bit are sampled on every converter clock. They move a phase counter with 96 positions, which wraps in both directions. Each of the three lanes reads the counter at its own fixed phase offset, folds that phase into a triangle amplitude of 48 levels, and feeds the amplitude to a first-order accumulator modulator. When no steps arrive, the phase stands still and the waveforms have zero frequency. An unbroken run of steps in one direction sweeps a full period every 96 clocks, which is the highest frequency the block can produce.

The step decoder has three named states, chosen fresh each cycle from the inputs: HOLD (strobe low, so the counter keeps its value), INC (strobe high and direction up, so the counter advances and wraps from 95 to 0) and DEC (strobe high and direction down, so the counter retreats and wraps from 0 to 95). Any state can lead to any other on the next cycle. The raw counter and the three amplitudes are brought out so that the waveform generation can be checked.

Top module: `tpd_synth`

## Requirements
- R1: After reset, and at every later time, `phase_cnt` is in the range 0 to 95. Reset (active-low `rst_n`) forces it to 0.
- R2: A clock edge with `step_valid`=1 and `step_up`=1 adds one to `phase_cnt`, and 95 wraps to 0.
- R3: A clock edge with `step_valid`=1 and `step_up`=0 subtracts one from `phase_cnt`, and 0 wraps to 95.
- R4: A clock edge with `step_valid`=0 leaves `phase_cnt` unchanged, whatever the value of `step_up`.
- R5: Lane k (k = 0, 1, 2) reads phase q = (`phase_cnt` + 32·k) mod 96. Its amplitude is q when q < 48 and 95 − q otherwise, so it never exceeds 47. The amplitude of lane k is presented combinationally on `tri_amp[6k+5:6k]`.
- R6: Each lane's modulator is clocked. Over any 48 consecutive clock edges during which a lane's amplitude stays at a value a, bit k of `pdm_out` is 1 exactly a times. Each bit is registered, so it reflects the amplitude that was present before the edge that produced it.
- R7: While reset is asserted, `pdm_out` is 0 and every modulator accumulator is cleared.
- R8: After 96 consecutive INC steps, `phase_cnt` returns to its starting value, and every lane passes through every amplitude on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | Step strobe: a step is applied on this edge |
| step_up | input | 1 | Step direction: 1 advances the phase, 0 retreats it |
| phase_cnt | output | 7 | Phase counter, 0 to 95 |
| tri_amp | output | 18 | Three 6-bit triangle amplitudes, lane k in bits [6k+5:6k] |
| pdm_out | output | 3 | Pulse-density bit of each lane, lane k in bit k |

## Verification
The assertions check, on every cycle, that the counter stays within its 96 states, that each step or hold moves it by the right amount with wrap-around, that no amplitude exceeds 47, and that each accumulator stays below full scale and emits no pulse while its amplitude and accumulator are both zero. Only the bench scenarios can show that the lanes sit exactly 32 counts apart across a full period. They also show that the count of ones over 48 cycles matches the amplitude for several held phases, and that a run of 96 steps closes the period.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    // Per-cycle step decision taken from the strobe and the direction bit.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    // Smallest width that holds values 0 .. n-1.
    function automatic int unsigned width_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) < n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/tpd_phase_counter.sv
module tpd_phase_counter
    import tpd_pkg::*;
#(
    parameter int unsigned STATES = 96,
    parameter int unsigned CW     = width_for(STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_valid,
    input  logic          step_up,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(STATES - 1);
    localparam logic [CW-1:0] ZERO = '0;

    step_e         step;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Decode the step state from the inputs.
    always_comb begin
        unique case ({step_valid, step_up})
            2'b11:   step = STEP_INC;
            2'b10:   step = STEP_DEC;
            default: step = STEP_HOLD;
        endcase
    end

    // Next-phase selection for each step state.
    always_comb begin
        cnt_d = cnt_q;
        unique case (step)
            STEP_HOLD: cnt_d = cnt_q;
            STEP_INC:  cnt_d = (cnt_q == LAST) ? ZERO : cnt_q + 1'b1;
            STEP_DEC:  cnt_d = (cnt_q == ZERO) ? LAST : cnt_q - 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R1: the phase never leaves its 96 states.
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: an up step advances by one and wraps at the top.
    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_up) |=>
        (cnt_q == (($past(cnt_q) == LAST) ? ZERO : $past(cnt_q) + 1'b1)));

    // R3: a down step retreats by one and wraps at the bottom.
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_up) |=>
        (cnt_q == (($past(cnt_q) == ZERO) ? LAST : $past(cnt_q) - 1'b1)));

    // R4: no strobe, no movement.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(cnt_q));

endmodule

// File: rtl/tpd_triangle.sv
module tpd_triangle #(
    parameter int unsigned STATES = 96,
    parameter int unsigned OFFSET = 0,
    parameter int unsigned CW     = 7,
    parameter int unsigned AW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] amp
);

    localparam int unsigned HALF = STATES / 2;
    localparam logic [CW:0] MOD  = (CW + 1)'(STATES);
    localparam logic [CW:0] OFS  = (CW + 1)'(OFFSET % STATES);
    localparam logic [CW:0] TOP  = (CW + 1)'(STATES - 1);
    localparam logic [CW:0] MID  = (CW + 1)'(HALF);

    logic [CW:0] sum;
    logic [CW:0] phase;
    logic [CW:0] folded;

    // Shift the shared phase by this lane's offset, modulo the period.
    always_comb begin
        sum   = {1'b0, cnt} + OFS;
        phase = (sum >= MOD) ? sum - MOD : sum;
    end

    // Fold the phase into a rising then falling ramp.
    always_comb begin
        if (phase < MID) begin
            folded = phase;
        end else begin
            folded = TOP - phase;
        end
    end

    assign amp = AW'(folded);

    // R5: the amplitude stays inside its 48 levels.
    p_amp_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        amp < AW'(HALF));

endmodule

// File: rtl/tpd_pdm.sv
module tpd_pdm #(
    parameter int unsigned SCALE = 48,
    parameter int unsigned AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] amp,
    output logic          bit_out
);

    localparam logic [AW:0] FULL = (AW + 1)'(SCALE);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic [AW:0]   total;
    logic          carry;

    // Add the amplitude, emit a carry whenever full scale is reached.
    always_comb begin
        total = {1'b0, acc_q} + {1'b0, amp};
        carry = (total >= FULL);
        acc_d = carry ? AW'(total - FULL) : AW'(total);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            bit_out <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            bit_out <= carry;
        end
    end

    // R6: the accumulator remains below full scale.
    p_acc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < AW'(SCALE));

    // R6: a silent lane with an empty accumulator emits no pulse.
    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (amp == '0 && acc_q == '0) |=> !bit_out);

endmodule

// File: rtl/tpd_synth.sv
module tpd_synth
    import tpd_pkg::*;
#(
    parameter int unsigned STATES = 96,
    parameter int unsigned LANES  = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_valid,
    input  logic         step_up,
    output logic [6:0]   phase_cnt,
    output logic [17:0]  tri_amp,
    output logic [2:0]   pdm_out
);

    localparam int unsigned CW   = width_for(STATES);
    localparam int unsigned HALF = STATES / 2;
    localparam int unsigned AW   = width_for(HALF);
    localparam int unsigned STEP = STATES / LANES;

    logic [CW-1:0]       cnt;
    logic [LANES*AW-1:0] amps;
    logic [LANES-1:0]    bits;

    tpd_phase_counter #(
        .STATES (STATES),
        .CW     (CW)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_up    (step_up),
        .cnt        (cnt)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tpd_triangle #(
            .STATES (STATES),
            .OFFSET (k * STEP),
            .CW     (CW),
            .AW     (AW)
        ) u_tri (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .amp   (amps[k*AW +: AW])
        );

        tpd_pdm #(
            .SCALE (HALF),
            .AW    (AW)
        ) u_pdm (
            .clk     (clk),
            .rst_n   (rst_n),
            .amp     (amps[k*AW +: AW]),
            .bit_out (bits[k])
        );
    end

    assign phase_cnt = 7'(cnt);
    assign tri_amp   = 18'(amps);
    assign pdm_out   = 3'(bits);

    // R7: while reset is held the stream outputs are silent.
    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |-> (pdm_out == 3'b000));

endmodule

// File: tb/tpd_synth_bench.sv
`timescale 1ns/1ps
module tpd_synth_bench;

    logic        clk;
    logic        rst_n;
    logic        step_valid;
    logic        step_up;
    logic [6:0]  phase_cnt;
    logic [17:0] tri_amp;
    logic [2:0]  pdm_out;

    int total;
    int bad;
    bit done;

    tpd_synth u_tpd_synth (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_up    (step_up),
        .phase_cnt  (phase_cnt),
        .tri_amp    (tri_amp),
        .pdm_out    (pdm_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Each entry: {valid, up, expected phase after the edge}, starting from phase 0.
    localparam int NV = 12;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 1'b0, 7'd95},  // R3 wrap below zero
        {1'b1, 1'b0, 7'd94},  // R3
        {1'b1, 1'b1, 7'd95},  // R2
        {1'b1, 1'b1, 7'd0},   // R2 wrap above 95
        {1'b1, 1'b1, 7'd1},   // R2
        {1'b0, 1'b1, 7'd1},   // R4 hold with up set
        {1'b0, 1'b0, 7'd1},   // R4 hold with up clear
        {1'b1, 1'b0, 7'd0},   // R3
        {1'b1, 1'b0, 7'd95},  // R3 wrap
        {1'b0, 1'b1, 7'd95},  // R4
        {1'b1, 1'b1, 7'd0},   // R2 wrap
        {1'b1, 1'b1, 7'd1}    // R2
    };

    function automatic int tri_ref(input int p, input int k);
        int q;
        q = (p + 32 * k) % 96;
        return (q < 48) ? q : 95 - q;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_amps(input int p, input string tag);
        for (int k = 0; k < 3; k++) begin
            check(int'(tri_amp[6*k +: 6]) == tri_ref(p, k), tag,
                  int'(tri_amp[6*k +: 6]), tri_ref(p, k));
        end
    endtask

    // Hold the phase and count ones per lane over 48 edges (called at a negedge).
    task automatic pdm_window(input int p, input string tag);
        int ones [3];
        step_valid = 1'b0;
        for (int k = 0; k < 3; k++) ones[k] = 0;
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) ones[k] += int'(pdm_out[k]);
        end
        for (int k = 0; k < 3; k++) check(ones[k] == tri_ref(p, k), tag, ones[k], tri_ref(p, k));
    endtask

    initial begin
        int ph;
        total = 0;
        bad = 0;
        done = 0;
        rst_n = 1'b0;
        step_valid = 1'b0;
        step_up = 1'b0;
        repeat (3) @(negedge clk);
        // R1 / R7: reset state
        check(phase_cnt == 7'd0, "R1 reset phase", int'(phase_cnt), 0);
        check(pdm_out == 3'b000, "R7 reset pdm", int'(pdm_out), 0);
        check_amps(0, "R5 reset amplitudes");
        rst_n = 1'b1;

        // Vector table walk: R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            step_valid = VEC[i][8];
            step_up    = VEC[i][7];
            @(negedge clk);
            check(phase_cnt == VEC[i][6:0], "R2 R3 R4 vector step",
                  int'(phase_cnt), int'(VEC[i][6:0]));
            check_amps(int'(VEC[i][6:0]), "R5 vector amplitudes");
        end

        // R8: full period of up steps from a fresh reset, amplitudes each step (R5)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step_valid = 1'b1;
        step_up = 1'b1;
        for (int s = 1; s <= 96; s++) begin
            @(negedge clk);
            ph = s % 96;
            check(int'(phase_cnt) == ph, "R8 sweep phase", int'(phase_cnt), ph);
            check_amps(ph, "R5 sweep amplitudes");
        end
        check(phase_cnt == 7'd0, "R8 period closes", int'(phase_cnt), 0);

        // R6: density windows at several held phases
        pdm_window(0, "R6 density phase 0");
        step_valid = 1'b1;
        step_up = 1'b0;
        @(negedge clk);
        check(phase_cnt == 7'd95, "R3 step before window", int'(phase_cnt), 95);
        pdm_window(95, "R6 density phase 95");
        step_valid = 1'b1;
        step_up = 1'b1;
        repeat (48) @(negedge clk);
        check(phase_cnt == 7'd47, "R2 climb to peak", int'(phase_cnt), 47);
        pdm_window(47, "R6 density phase 47");

        // R4: hold with up toggling leaves everything in place
        step_valid = 1'b0;
        for (int c = 0; c < 6; c++) begin
            step_up = c[0];
            @(negedge clk);
            check(phase_cnt == 7'd47, "R4 long hold", int'(phase_cnt), 47);
        end

        // R7: reset in mid-run silences the streams and clears the phase
        rst_n = 1'b0;
        #1;
        check(pdm_out == 3'b000, "R7 async reset pdm", int'(pdm_out), 0);
        check(phase_cnt == 7'd0, "R1 async reset phase", int'(phase_cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        pdm_window(0, "R6 density after reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule